// File: doc/BRIEF.md
# BERT Receive Statistics and Interrupt Unit

This block sits behind the receive checker of a bit-error-rate tester. Each clock it may see one received bit, marked by a valid strobe and an error flag, and it also sees whether the checker is out of sync with the incoming pattern. Two saturating accumulators count the received bits and the errored bits, but only while the checker is in sync. A single-cycle performance-monitoring update pulse closes the current period. On that pulse both totals are copied into snapshot registers, and both accumulators start again from zero.

Software sees two live status bits: the error snapshot is nonzero, and the checker is out of sync. It also sees three sticky latched bits, each set by its own kind of event. The first is any counted bit error. The second is the error snapshot going from zero to nonzero. The third is any change of the out-of-sync state, in either direction. Software clears latched bits by writing ones at their positions. A per-bit enable mask selects which latched bits drive the single interrupt line.

Top module: `bert_pm_stats`

## Requirements
- R1: While `rst` is high at a clock edge, both snapshots, both live status bits, all latched bits and `irq` go to 0.
- R2: When `pm_upd` is high at a clock edge, `bit_snap` takes the number of in-sync valid bits since the previous update. That number includes the update cycle itself. The bit accumulator restarts from zero, and `bit_snap` is unchanged at every other edge.
- R3: When `pm_upd` is high at a clock edge, `err_snap` takes the number of in-sync valid bits with `bit_err` high since the previous update, including the update cycle. It is unchanged at every other edge.
- R4: A bit presented while `oos_in` is high adds to neither count.
- R5: Each count saturates at its all-ones value (2^ERR_W-1 and 2^BIT_W-1) and does not wrap.
- R6: `live_st[0]` is 1 exactly when `err_snap` is nonzero.
- R7: `live_st[1]` equals the value `oos_in` had at the previous clock edge.
- R8: `lat_st[0]` becomes 1 one edge after an in-sync valid bit with `bit_err` high.
- R9: `lat_st[1]` becomes 1 on the same edge where `live_st[0]` goes from 0 to 1, and not while it stays at 1.
- R10: `lat_st[2]` becomes 1 one edge after `oos_in` differs from `live_st[1]`, for a change in either direction.
- R11: A latched bit stays 1 until an edge with `clr_wr` high and the matching `clr_mask` bit high clears it. If a set event for that bit occurs at the same edge, the bit stays 1.
- R12: `irq` is 1 exactly when some bit of `lat_st & irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | A received bit is present this cycle |
| bit_err | input | 1 | The present bit mismatched the pattern |
| oos_in | input | 1 | Checker is out of sync |
| pm_upd | input | 1 | Closes the accumulation period |
| clr_wr | input | 1 | Write strobe for clearing latched bits |
| clr_mask | input | 3 | Ones select latched bits to clear |
| irq_en | input | 3 | Interrupt enable per latched bit |
| err_snap | output | ERR_W | Error-count snapshot |
| bit_snap | output | BIT_W | Received-bit snapshot |
| live_st | output | 2 | [0] errors nonzero, [1] out of sync |
| lat_st | output | 3 | [0] error seen, [1] count rose, [2] sync changed |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check the parts of the block's timing that can be stated locally. Snapshots hold between update pulses, and latched bits stay set unless cleared. An in-sync error sets the error latch on the next edge, and a mismatch between the sync input and the live sync bit sets the sync latch. A rise of the nonzero status comes with its latch, and `irq` is never high without an enabled latched bit. Some properties need whole periods to show: that the snapshot values are the correct counts, that bits presented out of sync are excluded, and that both counts saturate at their all-ones values. The bench's period sweeps show these over many lengths and patterns. Its directed cases show that a set wins over a simultaneous clear and that every enable mask drives `irq` correctly.

// File: rtl/bert_pm_pkg.sv
package bert_pm_pkg;

    // latched status bit positions
    localparam int LAT_N    = 3;
    localparam int LAT_ERR  = 0;
    localparam int LAT_CNT  = 1;
    localparam int LAT_SYNC = 2;

    // live status bit positions
    localparam int LIVE_N   = 2;
    localparam int LIVE_NZ  = 0;
    localparam int LIVE_OOS = 1;

    // qualified per-cycle events from the receive checker
    typedef struct packed {
        logic bit_ok;   // valid bit while in sync
        logic err_ok;   // errored valid bit while in sync
    } bert_evt_t;

    // latch set requests, packed so that bit index matches LAT_* positions
    typedef struct packed {
        logic sync_chg;
        logic cnt_rise;
        logic err_hit;
    } lat_set_t;

    function automatic bert_evt_t qualify(input logic vld, input logic err, input logic oos);
        bert_evt_t e;
        e.bit_ok = vld & ~oos;
        e.err_ok = vld & err & ~oos;
        return e;
    endfunction

endpackage

// File: rtl/bert_sat_acc.sv
module bert_sat_acc #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         close,
    output logic [W-1:0] snap,
    output logic         sum_nz
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] acc_q;
    logic [W-1:0] acc_sum;

    always_comb begin
        if (!inc || acc_q == MAXV)
            acc_sum = acc_q;
        else
            acc_sum = acc_q + ONE;
    end

    assign sum_nz = (acc_sum != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            snap  <= '0;
        end else if (close) begin
            snap  <= acc_sum;
            acc_q <= '0;
        end else begin
            acc_q <= acc_sum;
        end
    end
endmodule

// File: rtl/bert_sync_track.sv
module bert_sync_track (
    input  logic clk,
    input  logic rst,
    input  logic oos_in,
    output logic oos_q,
    output logic oos_chg
);
    always_ff @(posedge clk) begin
        if (rst) oos_q <= 1'b0;
        else     oos_q <= oos_in;
    end

    assign oos_chg = oos_in ^ oos_q;
endmodule

// File: rtl/bert_lat_bank.sv
module bert_lat_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_req,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] lat
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                lat[i] <= 1'b0;
            else if (set_req[i])
                lat[i] <= 1'b1;
            else if (clr_wr && clr_mask[i])
                lat[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/bert_pm_stats.sv
module bert_pm_stats
    import bert_pm_pkg::*;
#(
    parameter int ERR_W = 24,
    parameter int BIT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              bit_err,
    input  logic              oos_in,
    input  logic              pm_upd,
    input  logic              clr_wr,
    input  logic [LAT_N-1:0]  clr_mask,
    input  logic [LAT_N-1:0]  irq_en,
    output logic [ERR_W-1:0]  err_snap,
    output logic [BIT_W-1:0]  bit_snap,
    output logic [LIVE_N-1:0] live_st,
    output logic [LAT_N-1:0]  lat_st,
    output logic              irq
);
    bert_evt_t evt;
    lat_set_t  set_req;
    logic      err_sum_nz;
    logic      bit_sum_nz;
    logic      oos_q;
    logic      oos_chg;
    logic      snap_nz;

    assign evt = qualify(bit_vld, bit_err, oos_in);

    bert_sat_acc #(.W(ERR_W)) u_err_acc (
        .clk    (clk),
        .rst    (rst),
        .inc    (evt.err_ok),
        .close  (pm_upd),
        .snap   (err_snap),
        .sum_nz (err_sum_nz)
    );

    bert_sat_acc #(.W(BIT_W)) u_bit_acc (
        .clk    (clk),
        .rst    (rst),
        .inc    (evt.bit_ok),
        .close  (pm_upd),
        .snap   (bit_snap),
        .sum_nz (bit_sum_nz)
    );

    bert_sync_track u_sync (
        .clk     (clk),
        .rst     (rst),
        .oos_in  (oos_in),
        .oos_q   (oos_q),
        .oos_chg (oos_chg)
    );

    assign snap_nz = (err_snap != '0);

    always_comb begin
        set_req          = '0;
        set_req.err_hit  = evt.err_ok;
        set_req.cnt_rise = pm_upd & err_sum_nz & ~snap_nz;
        set_req.sync_chg = oos_chg;
    end

    bert_lat_bank #(.N(LAT_N)) u_lat (
        .clk      (clk),
        .rst      (rst),
        .set_req  (set_req),
        .clr_wr   (clr_wr),
        .clr_mask (clr_mask),
        .lat      (lat_st)
    );

    always_comb begin
        live_st           = '0;
        live_st[LIVE_NZ]  = snap_nz;
        live_st[LIVE_OOS] = oos_q;
    end

    assign irq = |(lat_st & irq_en);

    logic unused_ok;
    assign unused_ok = bit_sum_nz;
endmodule

// File: rtl/bert_pm_stats_chk.sv
module bert_pm_stats_chk #(
    parameter int ERR_W = 24,
    parameter int BIT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_vld,
    input logic             bit_err,
    input logic             oos_in,
    input logic             pm_upd,
    input logic             clr_wr,
    input logic [2:0]       clr_mask,
    input logic [2:0]       irq_en,
    input logic [ERR_W-1:0] err_snap,
    input logic [BIT_W-1:0] bit_snap,
    input logic [1:0]       live_st,
    input logic [2:0]       lat_st,
    input logic             irq
);
    assert_bit_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(pm_upd) && !$past(rst)) |-> $stable(bit_snap));

    assert_err_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(pm_upd) && !$past(rst)) |-> $stable(err_snap));

    assert_live_oos_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (live_st[1] == $past(oos_in)));

    assert_err_set_R8: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && bit_err && !oos_in) |=> lat_st[0]);

    assert_cnt_rise_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(live_st[0]) |-> lat_st[1]);

    assert_sync_set_R10: assert property (@(posedge clk) disable iff (rst)
        (oos_in != live_st[1]) |=> lat_st[2]);

    for (genvar i = 0; i < 3; i++) begin : g_sticky
        assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
            (lat_st[i] && !(clr_wr && clr_mask[i])) |=> lat_st[i]);
    end

    assert_irq_src_R12: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((lat_st & irq_en) != 3'b000));
endmodule

bind bert_pm_stats bert_pm_stats_chk #(.ERR_W(ERR_W), .BIT_W(BIT_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .bit_vld  (bit_vld),
    .bit_err  (bit_err),
    .oos_in   (oos_in),
    .pm_upd   (pm_upd),
    .clr_wr   (clr_wr),
    .clr_mask (clr_mask),
    .irq_en   (irq_en),
    .err_snap (err_snap),
    .bit_snap (bit_snap),
    .live_st  (live_st),
    .lat_st   (lat_st),
    .irq      (irq)
);

// File: tb/bert_pm_stats_tb_top.sv
`timescale 1ns/1ps
module bert_pm_stats_tb_top;
    localparam int EW   = 4;
    localparam int BW   = 6;
    localparam int EMAX = (1 << EW) - 1;
    localparam int BMAX = (1 << BW) - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          bit_vld, bit_err, oos_in, pm_upd, clr_wr;
    logic [2:0]    clr_mask, irq_en;
    logic [EW-1:0] err_snap;
    logic [BW-1:0] bit_snap;
    logic [1:0]    live_st;
    logic [2:0]    lat_st;
    logic          irq;

    int total = 0;
    int bad   = 0;
    int prev_nz = 0;

    always #2 clk = ~clk;

    bert_pm_stats #(.ERR_W(EW), .BIT_W(BW)) dut_i (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_err(bit_err),
        .oos_in(oos_in), .pm_upd(pm_upd), .clr_wr(clr_wr),
        .clr_mask(clr_mask), .irq_en(irq_en), .err_snap(err_snap),
        .bit_snap(bit_snap), .live_st(live_st), .lat_st(lat_st), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        bit_vld = 0; bit_err = 0; pm_upd = 0; clr_wr = 0; clr_mask = 0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        quiet(); clr_wr = 1; clr_mask = 3'b111;
        @(negedge clk);
        quiet();
    endtask

    function automatic int mn(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // one accumulation period of length len with pattern p, then update
    task automatic run_period(input int len, input int p);
        int eb = 0, ee = 0, lo = 0, hi = 0, nz;
        if (p == 2) begin lo = len / 3; hi = (2 * len) / 3; end
        if (p == 3) begin lo = 0; hi = len; end
        clear_all();
        for (int i = 0; i < len; i++) begin
            bit_vld = (p == 1) ? (i % 3 != 1) : 1'b1;
            bit_err = (i % (p + 2)) == 0;
            oos_in  = (p >= 2) && (i >= lo) && (i < hi);
            if (bit_vld && !oos_in) eb++;
            if (bit_vld && bit_err && !oos_in) ee++;
            @(negedge clk);
        end
        quiet(); oos_in = 0; pm_upd = 1;
        @(negedge clk);
        quiet();
        nz = (mn(ee, EMAX) != 0) ? 1 : 0;
        chk($sformatf("R2/R5 bit_snap len=%0d p=%0d", len, p), int'(bit_snap), mn(eb, BMAX));
        chk($sformatf("R3/R4/R5 err_snap len=%0d p=%0d", len, p), int'(err_snap), mn(ee, EMAX));
        chk("R6 live nonzero", int'(live_st[0]), nz);
        chk("R8 error latch", int'(lat_st[0]), (ee > 0) ? 1 : 0);
        chk("R9 count-rise latch", int'(lat_st[1]), (prev_nz == 0 && nz == 1) ? 1 : 0);
        chk("R10 sync latch", int'(lat_st[2]), (hi > lo) ? 1 : 0);
        chk("R7 live oos after period", int'(live_st[1]), 0);
        prev_nz = nz;
    endtask

    initial begin
        #(200000 * 4);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1; quiet(); oos_in = 0; irq_en = 0;
        repeat (3) @(negedge clk);
        chk("R1 err_snap reset", int'(err_snap), 0);
        chk("R1 bit_snap reset", int'(bit_snap), 0);
        chk("R1 live reset", int'(live_st), 0);
        chk("R1 latch reset", int'(lat_st), 0);
        chk("R1 irq reset", int'(irq), 0);
        rst = 0;

        // sweep of period lengths and patterns
        for (int len = 0; len <= 70; len += 7)
            for (int p = 0; p < 4; p++)
                run_period(len, p);

        // R2/R3: bit on the update cycle counts into the closing period
        clear_all();
        for (int i = 0; i < 5; i++) begin bit_vld = 1; @(negedge clk); end
        quiet(); bit_vld = 1; bit_err = 1; pm_upd = 1;
        @(negedge clk);
        quiet();
        chk("R2 update-cycle bit counted", int'(bit_snap), 6);
        chk("R3 update-cycle error counted", int'(err_snap), 1);
        pm_upd = 1; @(negedge clk); quiet();
        chk("R2 restart from zero", int'(bit_snap), 0);
        chk("R3 restart from zero", int'(err_snap), 0);

        // R11: set wins over clear, then a plain clear
        clear_all();
        bit_vld = 1; bit_err = 1; @(negedge clk); quiet();
        chk("R8 single error latch", int'(lat_st[0]), 1);
        bit_vld = 1; bit_err = 1; clr_wr = 1; clr_mask = 3'b001;
        @(negedge clk); quiet();
        chk("R11 set beats clear", int'(lat_st[0]), 1);
        @(negedge clk);
        chk("R11 sticky without clear", int'(lat_st[0]), 1);
        clr_wr = 1; clr_mask = 3'b001; @(negedge clk); quiet();
        chk("R11 clear by write-1", int'(lat_st[0]), 0);

        // R7/R10: sync input rise
        oos_in = 1; @(negedge clk);
        chk("R7 live oos follows", int'(live_st[1]), 1);
        chk("R10 sync latch on rise", int'(lat_st[2]), 1);
        oos_in = 0; @(negedge clk);
        chk("R7 live oos falls", int'(live_st[1]), 0);

        // R12: all latches set, sweep enables
        pm_upd = 1; @(negedge clk); quiet();
        bit_vld = 1; bit_err = 1; @(negedge clk); quiet();
        pm_upd = 1; @(negedge clk); quiet();
        oos_in = 1; @(negedge clk); oos_in = 0; @(negedge clk);
        chk("R9 latch with rise", int'(lat_st[1]), 1);
        for (int m = 0; m < 8; m++) begin
            irq_en = 3'(m); #1;
            chk($sformatf("R12 irq en=%0d lat=%0d", m, lat_st), int'(irq), ((lat_st & 3'(m)) != 0) ? 1 : 0);
        end
        irq_en = 0;
        @(negedge clk); clr_wr = 1; clr_mask = 3'b101; @(negedge clk); quiet();
        chk("R11 masked clear keeps bit1", int'(lat_st), 3'b010);
        for (int m = 0; m < 8; m++) begin
            irq_en = 3'(m); #1;
            chk($sformatf("R12 irq partial en=%0d", m), int'(irq), ((m & 2) != 0) ? 1 : 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule